// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block turns a one-cycle request into the full bus conversation that an asynchronous parallel NOR flash with an 8-bit data path and a 17-bit address expects for two operations. The first writes one byte at an address. The second erases the 16 KB sector that holds an address. The device has eight such sectors in 128 KB, and the top three address bits select the sector. For each request the sequencer sends the unlock command writes and then the operation write. It then reads the target location repeatedly and watches the status bits until the device reports success or failure, or until a cycle watchdog gives up.

A host drives `req_valid_i` for one cycle with the operation kind, address and data. `busy_o` stays high until the single-cycle `done_o` pulse, and `error_o` is valid in that same cycle. The flash pins are registered strobes. Each write or read pulse lasts a parameterised number of clock cycles and is followed by one recovery cycle with all strobes released.

Top module: `nor_flash_seq`

## Requirements
- R1: A program request produces exactly four bus writes, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, and then the request data to the request address.
- R2: An erase request produces exactly six bus writes, in this order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, and then 0x30 to the request address. Bits 16:14 of the request address name the sector.
- R3: During a bus write, chip enable and write enable are both low for exactly PULSE_CYC cycles. Output enable stays high, and the address and data are stable for the whole pulse.
- R4: During a bus read, chip enable and output enable are low and write enable is high. The data pins are not driven, and the byte is captured in the last cycle of the pulse.
- R5: After a program write, the sequencer reads the target address until read bit 7 equals bit 7 of the programmed byte. It then finishes without error.
- R6: If a poll read shows bit 5 set and bit 7 not yet matching, exactly one more read is made. The operation fails only if bit 7 of that read still mismatches; otherwise it succeeds.
- R7: After an erase write, polling succeeds when read bit 7 is 1. If polling ends on bit 5 and the extra read still shows bit 7 at 0, the erase fails.
- R8: The poll phase has a watchdog, with PROG_WD_CYC cycles for program and ERASE_WD_CYC cycles for erase. It starts counting after the operation write. When it expires with no completion seen, the read in flight finishes and the operation ends with the error flag set.
- R9: `busy_o` rises in the cycle after a request is accepted and stays high through `done_o`. A request raised while busy is ignored and produces no bus activity.
- R10: `done_o` is high for exactly one cycle, with `error_o` valid in that cycle. After reset the block is idle with all strobes high and the data pins undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken only while idle |
| req_erase_i | input | 1 | 1 = sector erase, 0 = byte program |
| req_addr_i | input | 17 | Target address |
| req_data_i | input | 8 | Byte to program (ignored for erase) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Failure flag, valid with done_o |
| flash_addr_o | output | 17 | Flash address pins |
| flash_dq_o | output | 8 | Flash data out |
| flash_dq_oe_o | output | 1 | Data output enable toward the flash |
| flash_dq_i | input | 8 | Flash data in |
| flash_ce_no | output | 1 | Chip enable, active low |
| flash_we_no | output | 1 | Write enable, active low |
| flash_oe_no | output | 1 | Output enable, active low |

## Verification
The bench checks `busy_o` one cycle after the request edge. It waits for `done_o` by sampling on falling edges, then checks that the pulse has cleared one cycle later. A flash model logs each write at the rising edge of write enable, so command order is checked against that log and never against pin timing. The model's read counter advances on each rising edge of output enable, so poll and verify reads are counted exactly. For watchdog cases, the time from the final logged write to `done_o` must be at least the limit and no more than one read period plus a small margin beyond it.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_PULSE, PH_RECOV} phy_state_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_CMD, SQ_POLL, SQ_CHECK, SQ_DONE} seq_state_e;
  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_A         = 8'hAA;
  localparam logic [7:0]  KEY_B         = 8'h55;
  localparam logic [7:0]  OP_PROGRAM    = 8'hA0;
  localparam logic [7:0]  OP_ERASE_PRE  = 8'h80;
  localparam logic [7:0]  OP_ERASE_SECT = 8'h30;
  localparam int unsigned BIT_DONE      = 7;
  localparam int unsigned BIT_TIMEOUT   = 5;
endpackage

// File: rtl/nfs_cmd_gen.sv
module nfs_cmd_gen import nfs_pkg::*; #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              erase_i,
  input  logic [2:0]        step_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_data_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] A_A = ADDR_W'(UNLOCK_ADDR_A);
  localparam logic [ADDR_W-1:0] A_B = ADDR_W'(UNLOCK_ADDR_B);

  always_comb begin
    cmd_addr_o = A_A;
    cmd_data_o = DATA_W'(KEY_A);
    last_o     = 1'b0;
    case (step_i)
      3'd0: begin cmd_addr_o = A_A; cmd_data_o = DATA_W'(KEY_A); end
      3'd1: begin cmd_addr_o = A_B; cmd_data_o = DATA_W'(KEY_B); end
      3'd2: begin
        cmd_addr_o = A_A;
        cmd_data_o = erase_i ? DATA_W'(OP_ERASE_PRE) : DATA_W'(OP_PROGRAM);
      end
      3'd3: begin
        if (erase_i) begin
          cmd_addr_o = A_A; cmd_data_o = DATA_W'(KEY_A);
        end else begin
          cmd_addr_o = op_addr_i; cmd_data_o = op_data_i; last_o = 1'b1;
        end
      end
      3'd4: begin cmd_addr_o = A_B; cmd_data_o = DATA_W'(KEY_B); end
      3'd5: begin
        cmd_addr_o = op_addr_i; cmd_data_o = DATA_W'(OP_ERASE_SECT); last_o = 1'b1;
      end
      default: begin cmd_addr_o = op_addr_i; cmd_data_o = op_data_i; last_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/nfs_bus_phy.sv
module nfs_bus_phy import nfs_pkg::*; #(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              ce_no,
  output logic              we_no,
  output logic              oe_no
);
  localparam int unsigned CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYC - 1);

  phy_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        PH_IDLE: if (start_i) begin
          wr_q    <= write_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          cnt_q   <= '0;
          st_q    <= PH_PULSE;
        end
        PH_PULSE: begin
          if (cnt_q == CNT_LAST) begin
            if (!wr_q) rdata_q <= dq_i;  // sample at end of read pulse
            st_q <= PH_RECOV;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_RECOV: st_q <= PH_IDLE;
        default:  st_q <= PH_IDLE;
      endcase
    end
  end

  assign ack_o   = (st_q == PH_RECOV);
  assign rdata_o = rdata_q;
  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign dq_oe_o = wr_q && (st_q != PH_IDLE);
  assign ce_no   = (st_q != PH_PULSE);
  assign we_no   = !((st_q == PH_PULSE) && wr_q);
  assign oe_no   = !((st_q == PH_PULSE) && !wr_q);
endmodule

// File: rtl/nfs_watchdog.sv
module nfs_watchdog #(
  parameter int unsigned PROG_WD_CYC  = 4000,
  parameter int unsigned ERASE_WD_CYC = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic erase_i,
  output logic expired_o
);
  localparam int unsigned MAX_CYC = (PROG_WD_CYC > ERASE_WD_CYC) ? PROG_WD_CYC : ERASE_WD_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit     = erase_i ? CNT_W'(ERASE_WD_CYC) : CNT_W'(PROG_WD_CYC);
  assign expired_o = (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (run_i && !expired_o)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq import nfs_pkg::*; #(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PULSE_CYC    = 4,
  parameter int unsigned PROG_WD_CYC  = 4000,
  parameter int unsigned ERASE_WD_CYC = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_erase_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DATA_W-1:0] flash_dq_o,
  output logic              flash_dq_oe_o,
  input  logic [DATA_W-1:0] flash_dq_i,
  output logic              flash_ce_no,
  output logic              flash_we_no,
  output logic              flash_oe_no
);
  seq_state_e        st_q;
  logic              erase_q, err_q, inflight_q;
  logic [2:0]        step_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              cmd_last;
  logic              phy_start, phy_ack;
  logic [DATA_W-1:0] phy_rdata;
  logic              wd_expired;
  logic              want_bus, exp_b7;
  logic              rd_match, rd_timeout;

  nfs_cmd_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cmd_gen (
    .erase_i    (erase_q),
    .step_i     (step_q),
    .op_addr_i  (addr_q),
    .op_data_i  (data_q),
    .cmd_addr_o (cmd_addr),
    .cmd_data_o (cmd_data),
    .last_o     (cmd_last)
  );

  assign want_bus  = (st_q == SQ_CMD) || (st_q == SQ_POLL) || (st_q == SQ_CHECK);
  assign phy_start = want_bus && !inflight_q;

  nfs_bus_phy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)) i_phy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (phy_start),
    .write_i (st_q == SQ_CMD),
    .addr_i  ((st_q == SQ_CMD) ? cmd_addr : addr_q),
    .wdata_i (cmd_data),
    .dq_i    (flash_dq_i),
    .ack_o   (phy_ack),
    .rdata_o (phy_rdata),
    .addr_o  (flash_addr_o),
    .dq_o    (flash_dq_o),
    .dq_oe_o (flash_dq_oe_o),
    .ce_no   (flash_ce_no),
    .we_no   (flash_we_no),
    .oe_no   (flash_oe_no)
  );

  nfs_watchdog #(.PROG_WD_CYC(PROG_WD_CYC), .ERASE_WD_CYC(ERASE_WD_CYC)) i_wd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (st_q == SQ_CMD),
    .run_i     ((st_q == SQ_POLL) || (st_q == SQ_CHECK)),
    .erase_i   (erase_q),
    .expired_o (wd_expired)
  );

  // erased cells read back with bit 7 set
  assign exp_b7     = erase_q ? 1'b1 : data_q[BIT_DONE];
  assign rd_match   = (phy_rdata[BIT_DONE] == exp_b7);
  assign rd_timeout = phy_rdata[BIT_TIMEOUT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      erase_q    <= 1'b0;
      err_q      <= 1'b0;
      inflight_q <= 1'b0;
      step_q     <= '0;
      addr_q     <= '0;
      data_q     <= '0;
    end else begin
      if (phy_start)    inflight_q <= 1'b1;
      else if (phy_ack) inflight_q <= 1'b0;
      case (st_q)
        SQ_IDLE: if (req_valid_i) begin
          erase_q <= req_erase_i;
          addr_q  <= req_addr_i;
          data_q  <= req_data_i;
          step_q  <= '0;
          err_q   <= 1'b0;
          st_q    <= SQ_CMD;
        end
        SQ_CMD: if (phy_ack) begin
          if (cmd_last) st_q <= SQ_POLL;
          else          step_q <= step_q + 1'b1;
        end
        SQ_POLL: if (phy_ack) begin
          if (rd_match) begin
            err_q <= 1'b0;
            st_q  <= SQ_DONE;
          end else if (rd_timeout) begin
            st_q <= SQ_CHECK;
          end else if (wd_expired) begin
            err_q <= 1'b1;
            st_q  <= SQ_DONE;
          end
        end
        SQ_CHECK: if (phy_ack) begin
          err_q <= !rd_match;
          st_q  <= SQ_DONE;
        end
        SQ_DONE: st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign done_o  = (st_q == SQ_DONE);
  assign error_o = (st_q == SQ_DONE) && err_q;
endmodule

// File: rtl/nor_flash_seq_chk.sv
module nor_flash_seq_chk #(
  parameter int unsigned PULSE_CYC = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        error_o,
  input logic [16:0] flash_addr_o,
  input logic [7:0]  flash_dq_o,
  input logic        flash_dq_oe_o,
  input logic        flash_ce_no,
  input logic        flash_we_no,
  input logic        flash_oe_no
);
  logic [15:0] we_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          we_low_cnt <= '0;
    else if (!flash_we_no) we_low_cnt <= we_low_cnt + 1'b1;
    else                  we_low_cnt <= '0;
  end

  p_write_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_we_no) |-> (we_low_cnt == 16'(PULSE_CYC)));

  p_write_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no && $past(!flash_we_no)) |-> ($stable(flash_addr_o) && $stable(flash_dq_o)));

  p_write_strobes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_no |-> (!flash_ce_no && flash_oe_no && flash_dq_oe_o));

  p_read_strobes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_oe_no |-> (!flash_ce_no && flash_we_no && !flash_dq_oe_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_error_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  p_done_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (flash_ce_no && flash_we_no && flash_oe_no));
endmodule

bind nor_flash_seq nor_flash_seq_chk #(.PULSE_CYC(PULSE_CYC)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .error_o       (error_o),
  .flash_addr_o  (flash_addr_o),
  .flash_dq_o    (flash_dq_o),
  .flash_dq_oe_o (flash_dq_oe_o),
  .flash_ce_no   (flash_ce_no),
  .flash_we_no   (flash_we_no),
  .flash_oe_no   (flash_oe_no)
);

// File: tb/test_nor_flash_seq.sv
module test_nor_flash_seq;
  localparam int PULSE = 3;
  localparam int PWD   = 150;
  localparam int EWD   = 300;
  localparam int M_OK = 0, M_FAIL = 1, M_HANG = 2, M_LATE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_erase = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic busy, done, error, dq_oe, ce_n, we_n, oe_n;
  logic [16:0] f_addr;
  logic [7:0]  f_dq_o, f_dq_i;

  always #2.5 clk = ~clk;

  nor_flash_seq #(.PULSE_CYC(PULSE), .PROG_WD_CYC(PWD), .ERASE_WD_CYC(EWD)) i_nor_flash_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_erase_i(req_erase),
    .req_addr_i(req_addr), .req_data_i(req_data), .busy_o(busy), .done_o(done),
    .error_o(error), .flash_addr_o(f_addr), .flash_dq_o(f_dq_o), .flash_dq_oe_o(dq_oe),
    .flash_dq_i(f_dq_i), .flash_ce_no(ce_n), .flash_we_no(we_n), .flash_oe_no(oe_n)
  );

  int checks = 0, fails = 0;
  int cyc = 0;

  // flash model
  int          mode = M_OK, busy_n = 0, rd_cnt = 0, wcnt = 0, last_wr_cyc = 0;
  logic [7:0]  target = 8'h00;
  logic        mdl_clr = 1'b0;
  logic        we_d = 1'b1, oe_d = 1'b1;
  logic [16:0] log_a [8];
  logic [7:0]  log_d [8];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    we_d <= we_n;
    oe_d <= oe_n;
    if (mdl_clr) begin
      wcnt <= 0; rd_cnt <= 0;
    end else begin
      if (we_n && !we_d) begin
        if (wcnt < 8) begin log_a[wcnt] <= f_addr; log_d[wcnt] <= f_dq_o; end
        wcnt <= wcnt + 1;
        last_wr_cyc <= cyc;
      end
      if (oe_n && !oe_d) rd_cnt <= rd_cnt + 1;
    end
  end

  always_comb begin
    if (rd_cnt < busy_n) f_dq_i = {~target[7], rd_cnt[0], 6'b0};
    else case (mode)
      M_OK:    f_dq_i = target;
      M_FAIL:  f_dq_i = {~target[7], 1'b0, 1'b1, 5'b0};
      M_LATE:  f_dq_i = (rd_cnt == busy_n) ? {~target[7], 1'b0, 1'b1, 5'b0} : target;
      default: f_dq_i = {~target[7], 7'b0};
    endcase
  end

  function automatic logic [16:0] exp_a(bit er, int i, logic [16:0] a);
    if (!er) return (i == 0 || i == 2) ? 17'h05555 : (i == 1) ? 17'h02AAA : a;
    case (i)
      0, 2, 3: return 17'h05555;
      1, 4:    return 17'h02AAA;
      default: return a;
    endcase
  endfunction

  function automatic logic [7:0] exp_d(bit er, int i, logic [7:0] d);
    if (!er) return (i == 0) ? 8'hAA : (i == 1) ? 8'h55 : (i == 2) ? 8'hA0 : d;
    case (i)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2:    return 8'h80;
      default: return 8'h30;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_op(bit er, logic [16:0] a, logic [7:0] d, int md, int bn, bit inject);
    int n_exp, t0, t_done, good, bad_i;
    bit got_err, exp_err;
    @(negedge clk);
    mode = md; busy_n = bn; target = er ? 8'hFF : d;
    mdl_clr = 1'b1;
    @(negedge clk);
    mdl_clr = 1'b0;
    req_valid = 1'b1; req_erase = er; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9", "busy after accept", busy, 1);
    if (inject) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1; req_erase = ~er; req_addr = ~a; req_data = ~d;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t0 = cyc;
    while (done !== 1'b1 && cyc - t0 < 5000) @(negedge clk);
    t_done = cyc;
    got_err = error;
    chk(done === 1'b1, "R10", "done seen", done, 1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R10", "done one cycle then idle", {busy, done}, 0);
    n_exp = er ? 6 : 4;
    chk(wcnt == n_exp, er ? "R2" : "R1", "write count", wcnt, n_exp);
    good = 1; bad_i = 0;
    for (int i = 0; i < n_exp && i < 8; i++)
      if (log_a[i] !== exp_a(er, i, a) || log_d[i] !== exp_d(er, i, d)) begin
        if (good) bad_i = i;
        good = 0;
      end
    chk(good == 1, er ? "R2" : "R1", "write sequence", {log_a[bad_i], log_d[bad_i]},
        {exp_a(er, bad_i, a), exp_d(er, bad_i, d)});
    exp_err = (md == M_FAIL) || (md == M_HANG);
    chk(got_err == exp_err, (md == M_HANG) ? "R8" : (md == M_OK) ? (er ? "R7" : "R5") : "R6",
        "error flag", got_err, exp_err);
    if (md == M_OK)
      chk(rd_cnt == bn + 1, er ? "R7" : "R5", "poll reads", rd_cnt, bn + 1);
    else if (md != M_HANG)
      chk(rd_cnt == bn + 2, "R6", "reads incl. verify", rd_cnt, bn + 2);
    else begin
      int lim = er ? EWD : PWD;
      chk((t_done - last_wr_cyc) >= lim && (t_done - last_wr_cyc) <= lim + 4*PULSE + 8,
          "R8", "watchdog latency", t_done - last_wr_cyc, lim);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && error === 0, "R10", "reset outputs", {busy, done, error}, 0);
    chk(ce_n === 1 && we_n === 1 && oe_n === 1 && dq_oe === 0, "R10", "reset strobes",
        {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    do_op(1'b0, 17'h1_2345, 8'h96, M_OK,   0, 1'b0); // R5 immediate match
    do_op(1'b0, 17'h0_0001, 8'h17, M_OK,   3, 1'b0); // R5 bit7 = 0 data
    do_op(1'b0, 17'h0_ABCD, 8'hC3, M_FAIL, 2, 1'b0); // R6 fail
    do_op(1'b0, 17'h1_FFFF, 8'h80, M_LATE, 1, 1'b0); // R6 recover
    do_op(1'b1, 17'h1_C000, 8'h00, M_OK,   4, 1'b0); // R7 last sector
    do_op(1'b1, 17'h0_4123, 8'h00, M_FAIL, 0, 1'b0); // R7 fail
    do_op(1'b1, 17'h0_8765, 8'h00, M_LATE, 2, 1'b0); // R7 recover
    do_op(1'b0, 17'h0_3000, 8'h5A, M_HANG, 0, 1'b0); // R8 program limit
    do_op(1'b1, 17'h1_0000, 8'h00, M_HANG, 0, 1'b0); // R8 erase limit
    do_op(1'b0, 17'h0_2222, 8'hE1, M_OK,   2, 1'b1); // R9 request ignored
    do_op(1'b1, 17'h0_7777, 8'h00, M_OK,   1, 1'b1); // R9 request ignored
    for (int k = 0; k < 24; k++) begin
      int r = $urandom_range(0, 9);
      int md = (r < 5) ? M_OK : (r < 7) ? M_FAIL : (r < 9) ? M_LATE : M_HANG;
      do_op(1'($urandom_range(0, 1)), 17'($urandom), 8'($urandom), md,
            $urandom_range(0, 5), 1'($urandom_range(0, 1)));
    end
    finish_run();
  end

  initial begin
    wait (cyc >= 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
    finish_run();
  end
endmodule